// File: doc/BRIEF.md
# Reed-Solomon Codeword Input Framer

This block sits at the front of a Reed-Solomon decoding path. It takes one symbol per clock and labels each one for the corrector or delay line behind it. A codeword is framed by the level of a data-enable strobe: high while the N−r data symbols arrive, then low while the r parity symbols arrive. The next rising level starts the following codeword. For each symbol the block reports whether it belongs to a codeword, whether it is data or parity, and its position within the codeword. It also flags the first and last symbols of each codeword and raises an error flag when the strobe breaks the expected length pattern.

A decode-enable input selects between correction and unmodified pass-through. A codeword is released for correction only if decode-enable was high for every one of its symbols. Pass-through therefore takes hold at once, but correction resumes only at the next codeword start. When decode-enable is low and r is zero, the strobe is ignored and the stream is cut into back-to-back codewords of N data symbols.

The block also computes the downstream processing latency from N, r and two option selects. It holds that value, together with N and r, for the whole codeword. All outputs are registered and describe the symbol taken on the previous rising clock edge.

Top module: `rsf_codeword_framer`

## Requirements
- R1: While reset is asserted, and until the first symbol after it, `in_blk_o`, `is_par_o`, `blk_start_o`, `blk_end_o` and `frame_err_o` are 0, `idx_o` and `latency_o` are 0, and `pass_o` is 1.
- R2: Every output describes the symbol sampled on the previous rising edge, and `sym_o` is that symbol unchanged.
- R3: A symbol with the strobe high starts a codeword in three cases: when no codeword is open, after a completed parity phase, or (with r=0) after a completed data phase. The start symbol has `blk_start_o`=1, `in_blk_o`=1, `idx_o`=0 and `is_par_o`=0.
- R4: Inside a codeword, `idx_o` rises by one per symbol. Indices 0..N−r−1 are data (`is_par_o`=0) while the strobe is high, and indices N−r..N−1 are parity (`is_par_o`=1) while the strobe is low. `blk_end_o`=1 exactly on index N−1.
- R5: Symbols with the strobe low after a completed codeword are outside any codeword: `in_blk_o`=0, `idx_o`=0, `pass_o`=1, and no error is flagged.
- R6: With r=0 and decode-enable high, a codeword is N data symbols. If the strobe stays high, the next symbol starts a new codeword without error. If it falls, that symbol is outside any codeword, also without error.
- R7: If the strobe falls before N−r data symbols have arrived, that symbol gets `frame_err_o`=1 and `in_blk_o`=0. The block then waits for the next high strobe.
- R8: If the strobe is high after fewer than r parity symbols, or is still high after N−r data symbols when r>0, that symbol gets `frame_err_o`=1 and starts a new codeword.
- R9: For a symbol inside a codeword, `pass_o`=1 if decode-enable was low on that symbol or on any earlier symbol of the same codeword. Raising decode-enable has effect only from the next codeword start.
- R10: While decode-enable is low and r=0, the strobe level is ignored. Every symbol is data, and codewords of N symbols follow each other with no gap.
- R11: `latency_o` is 2N+5r+33 by default, 2N+2r+13 with option 1 selected, and floor(3(N+r)/2)+15 with option 2 selected, whatever the level of option 1.
- R12: N, r and the latency are sampled only on a codeword's start symbol. Changes to N, r or the option selects part way through a codeword do not affect that codeword's framing or its reported latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_en_i | input | 1 | Framing strobe: high for data symbols, low for parity symbols |
| dec_en_i | input | 1 | High to request correction, low for pass-through |
| sym_i | input | SYM_W | Incoming symbol |
| cfg_len_i | input | LEN_W | Codeword length N |
| cfg_par_i | input | LEN_W | Parity symbol count r |
| lat_opt1_i | input | 1 | Selects the first shortened latency formula |
| lat_opt2_i | input | 1 | Selects the second shortened latency formula; overrides option 1 |
| sym_o | output | SYM_W | Registered copy of the symbol |
| in_blk_o | output | 1 | Symbol belongs to a codeword |
| is_par_o | output | 1 | Symbol is a parity symbol |
| idx_o | output | LEN_W | Position of the symbol within its codeword |
| blk_start_o | output | 1 | First symbol of a codeword |
| blk_end_o | output | 1 | Last symbol of a codeword |
| frame_err_o | output | 1 | Strobe broke the expected length pattern on this symbol |
| pass_o | output | 1 | Symbol must pass through uncorrected |
| latency_o | output | LAT_W | Processing latency held for the current codeword |

## Verification
The assertions assume a legal configuration, 1 ≤ N and r < N, sampled on every start symbol. They also assume that inputs change away from the rising edge. All stimulus writes N and r only to legal pairs, and it moves inputs only on the falling edge. Malformed strobe patterns are still driven on purpose, since the block has to flag them. Configuration changes in the middle of a codeword are also driven on purpose, to show that the latched values stay in force until the next start.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_DATA = 2'd1,
    PH_PAR  = 2'd2
  } phase_e;

  typedef struct packed {
    logic in_blk;
    logic is_par;
    logic start;
    logic last;
    logic err;
  } tag_t;

endpackage

// File: rtl/rsf_frame_fsm.sv
module rsf_frame_fsm
  import rsf_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic             dec_en_i,
  input  logic [LEN_W-1:0] n_i,
  input  logic [LEN_W-1:0] r_i,
  output tag_t             tag_o,
  output logic [LEN_W-1:0] idx_o
);

  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] n_q, r_q;
  logic             cfg_ld;

  logic [LEN_W-1:0] r_eff, n_sel, nxt, dlen_q;
  logic             de_eff;
  tag_t             tag;
  logic [LEN_W-1:0] idx;

  // Outside a codeword the live r decides whether the strobe is ignored
  assign r_eff  = (phase_q == PH_HUNT) ? r_i : r_q;
  assign de_eff = de_i | (~dec_en_i & (r_eff == '0));
  assign nxt    = cnt_q + 1'b1;
  assign dlen_q = n_q - r_q;

  always_comb begin
    tag     = '0;
    idx     = '0;
    case (phase_q)
      PH_HUNT: begin
        if (de_eff) tag.start = 1'b1;
      end
      PH_DATA: begin
        if (de_eff) begin
          if (nxt < dlen_q) begin
            tag.in_blk = 1'b1;
            idx        = nxt;
          end else begin
            tag.start = 1'b1;
            tag.err   = (r_q != '0);
          end
        end else if (nxt == dlen_q) begin
          if (r_q != '0) begin
            tag.in_blk = 1'b1;
            tag.is_par = 1'b1;
            idx        = nxt;
          end
        end else begin
          tag.err = 1'b1;
        end
      end
      PH_PAR: begin
        if (de_eff) begin
          tag.start = 1'b1;
          tag.err   = (nxt != n_q);
        end else if (nxt < n_q) begin
          tag.in_blk = 1'b1;
          tag.is_par = 1'b1;
          idx        = nxt;
        end
      end
      default: ;
    endcase
    if (tag.start) begin
      tag.in_blk = 1'b1;
      tag.is_par = 1'b0;
      idx        = '0;
    end
    n_sel    = tag.start ? n_i : n_q;
    tag.last = tag.in_blk && (idx == n_sel - 1'b1);
  end

  always_comb begin
    cfg_ld = tag.start;
    cnt_d  = idx;
    if (!tag.in_blk)     phase_d = PH_HUNT;
    else if (tag.is_par) phase_d = PH_PAR;
    else                 phase_d = PH_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HUNT;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      r_q <= '0;
    end else if (cfg_ld) begin
      n_q <= n_i;
      r_q <= r_i;
    end
  end

  assign tag_o = tag;
  assign idx_o = idx;

  AST_PAR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAR) |-> (r_q != '0)); // R4

  AST_PAR_PAST_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAR) |-> (cnt_q >= dlen_q)); // R4

endmodule

// File: rtl/rsf_latency.sv
module rsf_latency #(
  parameter int LEN_W = 8,
  parameter int LAT_W = LEN_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [LEN_W-1:0] n_i,
  input  logic [LEN_W-1:0] r_i,
  input  logic             opt1_i,
  input  logic             opt2_i,
  output logic [LAT_W-1:0] lat_o
);

  logic [LAT_W-1:0] n_x, r_x, lat_dflt, lat_one, lat_two, lat_d, lat_q;

  assign n_x = LAT_W'(n_i);
  assign r_x = LAT_W'(r_i);

  always_comb begin
    lat_dflt = (n_x << 1) + (r_x << 2) + r_x + LAT_W'(33);
    lat_one  = (n_x << 1) + (r_x << 1) + LAT_W'(13);
    lat_two  = (((n_x + r_x) << 1) + (n_x + r_x)) >> 1;
    lat_two  = lat_two + LAT_W'(15);
    if (opt2_i)      lat_d = lat_two;
    else if (opt1_i) lat_d = lat_one;
    else             lat_d = lat_dflt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (ld_i) lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  AST_LAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(lat_q)); // R12

endmodule

// File: rtl/rsf_pass_track.sv
module rsf_pass_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_blk_i,
  input  logic start_i,
  input  logic dec_en_i,
  output logic pass_o
);

  logic taint_q, taint_d, taint_en;

  always_comb begin
    taint_en = in_blk_i;
    taint_d  = start_i ? ~dec_en_i : (taint_q | ~dec_en_i);
    pass_o   = in_blk_i ? taint_d : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taint_q <= 1'b1;
    else if (taint_en) taint_q <= taint_d;
  end

endmodule

// File: rtl/rsf_codeword_framer.sv
module rsf_codeword_framer
  import rsf_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int LEN_W = 8,
  parameter int LAT_W = LEN_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_en_i,
  input  logic             dec_en_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [LEN_W-1:0] cfg_par_i,
  input  logic             lat_opt1_i,
  input  logic             lat_opt2_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             in_blk_o,
  output logic             is_par_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             blk_start_o,
  output logic             blk_end_o,
  output logic             frame_err_o,
  output logic             pass_o,
  output logic [LAT_W-1:0] latency_o
);

  tag_t             tag;
  logic [LEN_W-1:0] idx;
  logic             pass_c;

  rsf_frame_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .de_i     (data_en_i),
    .dec_en_i (dec_en_i),
    .n_i      (cfg_len_i),
    .r_i      (cfg_par_i),
    .tag_o    (tag),
    .idx_o    (idx)
  );

  rsf_latency #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (tag.start),
    .n_i    (cfg_len_i),
    .r_i    (cfg_par_i),
    .opt1_i (lat_opt1_i),
    .opt2_i (lat_opt2_i),
    .lat_o  (latency_o)
  );

  rsf_pass_track u_pass (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_blk_i (tag.in_blk),
    .start_i  (tag.start),
    .dec_en_i (dec_en_i),
    .pass_o   (pass_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_o       <= '0;
      in_blk_o    <= 1'b0;
      is_par_o    <= 1'b0;
      idx_o       <= '0;
      blk_start_o <= 1'b0;
      blk_end_o   <= 1'b0;
      frame_err_o <= 1'b0;
      pass_o      <= 1'b1;
    end else begin
      sym_o       <= sym_i;
      in_blk_o    <= tag.in_blk;
      is_par_o    <= tag.is_par;
      idx_o       <= idx;
      blk_start_o <= tag.start;
      blk_end_o   <= tag.last;
      frame_err_o <= tag.err;
      pass_o      <= pass_c;
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |-> (in_blk_o && !is_par_o && idx_o == '0)); // R3

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk_o && !blk_start_o) |-> ($past(in_blk_o) && idx_o == LEN_W'($past(idx_o) + 1'b1))); // R4

  AST_UNFRAMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_blk_o |-> (!is_par_o && !blk_end_o && pass_o && idx_o == '0)); // R5

  AST_ERR_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> (!in_blk_o || blk_start_o)); // R7

  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk_o && !blk_start_o && $past(pass_o)) |-> pass_o); // R9

endmodule

// File: tb/sim_rsf_codeword_framer.sv
module sim_rsf_codeword_framer;

  localparam int SYM_W = 8;
  localparam int LEN_W = 8;
  localparam int LAT_W = LEN_W + 4;
  localparam int NVEC  = 35;

  // fields: de, dec_en, in_blk, is_par, idx[7:0], start, end, err, pass
  localparam logic [15:0] TBL [NVEC] = '{
    {1'b0,1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd2,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd3,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b1,8'd4,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b1,8'd5,1'b0,1'b1,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd2,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd3,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b1,8'd4,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b1,8'd5,1'b0,1'b1,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd2,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd3,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b1,8'd4,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b1,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd2,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd3,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b1,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,8'd2,1'b0,1'b0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'd3,1'b0,1'b0,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,8'd4,1'b0,1'b0,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,8'd5,1'b0,1'b1,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'd0,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'd1,1'b0,1'b0,1'b0,1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             data_en, dec_en, opt1, opt2;
  logic [SYM_W-1:0] sym;
  logic [LEN_W-1:0] cfg_len, cfg_par;
  logic [SYM_W-1:0] sym_o;
  logic             in_blk_o, is_par_o, blk_start_o, blk_end_o, frame_err_o, pass_o;
  logic [LEN_W-1:0] idx_o;
  logic [LAT_W-1:0] latency_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rsf_codeword_framer #(.SYM_W(SYM_W), .LEN_W(LEN_W), .LAT_W(LAT_W)) u0 (
    .clk (clk), .rst_n (rst_n), .data_en_i (data_en), .dec_en_i (dec_en),
    .sym_i (sym), .cfg_len_i (cfg_len), .cfg_par_i (cfg_par),
    .lat_opt1_i (opt1), .lat_opt2_i (opt2), .sym_o (sym_o),
    .in_blk_o (in_blk_o), .is_par_o (is_par_o), .idx_o (idx_o),
    .blk_start_o (blk_start_o), .blk_end_o (blk_end_o),
    .frame_err_o (frame_err_o), .pass_o (pass_o), .latency_o (latency_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one symbol at a falling edge, return at the next falling edge
  task automatic step(input logic de, input logic den, input logic [SYM_W-1:0] s);
    data_en = de;
    dec_en  = den;
    sym     = s;
    @(negedge clk);
  endtask

  task automatic flush();
    for (int k = 0; k < 70; k++) step(1'b0, 1'b1, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    data_en = 1'b1;
    dec_en  = 1'b1;
    sym     = 8'hA5;
    cfg_len = 8'd6;
    cfg_par = 8'd2;
    opt1    = 1'b0;
    opt2    = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "in_blk", int'(in_blk_o), 0);
    chk("R1", "start", int'(blk_start_o), 0);
    chk("R1", "err", int'(frame_err_o), 0);
    chk("R1", "pass", int'(pass_o), 1);
    chk("R1", "latency", int'(latency_o), 0);
    chk("R1", "idx", int'(idx_o), 0);
    data_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // table walk with N=6, r=2
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = TBL[i];
      step(v[15], v[14], SYM_W'(i + 8'h40));
      chk("R2", "sym", int'(sym_o), i + 'h40);
      chk(v[13] ? "R4" : "R5", "in_blk", int'(in_blk_o), int'(v[13]));
      chk("R4", "is_par", int'(is_par_o), int'(v[12]));
      chk("R4", "idx", int'(idx_o), int'(v[11:4]));
      chk("R3", "start", int'(blk_start_o), int'(v[3]));
      chk("R4", "end", int'(blk_end_o), int'(v[2]));
      chk("R7 R8", "err", int'(frame_err_o), int'(v[1]));
      chk("R9", "pass", int'(pass_o), int'(v[0]));
    end

    // R11 / R12: latency and configuration held for the codeword
    flush();
    step(1'b1, 1'b1, 8'h01);
    chk("R11", "default latency N6 r2", int'(latency_o), 55);
    opt2    = 1'b1;
    cfg_len = 8'd10;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 8'h02);
    chk("R12", "latency held", int'(latency_o), 55);
    step(1'b0, 1'b1, 8'h03);
    chk("R12", "parity at idx 4", int'(is_par_o), 1);
    step(1'b0, 1'b1, 8'h04);
    chk("R12", "end with latched N", int'(blk_end_o), 1);
    step(1'b1, 1'b1, 8'h05);
    chk("R12", "new start", int'(blk_start_o), 1);
    chk("R11", "opt2 latency N10 r2", int'(latency_o), 33);

    cfg_len = 8'd64;
    cfg_par = 8'd16;
    opt1 = 1'b0; opt2 = 1'b0;
    step(1'b0, 1'b1, 8'h00); step(1'b1, 1'b1, 8'h00);
    chk("R11", "default N64 r16", int'(latency_o), 241);
    opt1 = 1'b1; opt2 = 1'b0;
    step(1'b0, 1'b1, 8'h00); step(1'b1, 1'b1, 8'h00);
    chk("R11", "opt1 N64 r16", int'(latency_o), 173);
    opt1 = 1'b0; opt2 = 1'b1;
    step(1'b0, 1'b1, 8'h00); step(1'b1, 1'b1, 8'h00);
    chk("R11", "opt2 N64 r16", int'(latency_o), 135);
    opt1 = 1'b1; opt2 = 1'b1;
    step(1'b0, 1'b1, 8'h00); step(1'b1, 1'b1, 8'h00);
    chk("R11", "opt2 over opt1", int'(latency_o), 135);

    // R10: pass-through with r=0 ignores the strobe
    flush();
    cfg_len = 8'd3;
    cfg_par = 8'd0;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b0, 8'h10);
      chk("R10", "in_blk", int'(in_blk_o), 1);
      chk("R10", "idx", int'(idx_o), k % 3);
      chk("R10", "start", int'(blk_start_o), int'(k % 3 == 0));
      chk("R10", "end", int'(blk_end_o), int'(k % 3 == 2));
      chk("R10", "pass", int'(pass_o), 1);
    end
    // R6: r=0 with decoding, strobe held high
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b1, 8'h20);
      chk("R6", "idx", int'(idx_o), k % 3);
      chk("R6", "start", int'(blk_start_o), int'(k % 3 == 0));
      chk("R6", "err", int'(frame_err_o), 0);
      chk("R9", "pass cleared at boundary", int'(pass_o), 0);
    end
    step(1'b0, 1'b1, 8'h30);
    chk("R6", "fall after data", int'(in_blk_o), 0);
    chk("R6", "no error", int'(frame_err_o), 0);

    // R1: reset in the middle of a codeword
    step(1'b1, 1'b1, 8'h31);
    rst_n = 1'b0;
    #2;
    chk("R1", "async clear in_blk", int'(in_blk_o), 0);
    chk("R1", "async clear latency", int'(latency_o), 0);
    chk("R1", "async pass", int'(pass_o), 1);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end

endmodule